// File: doc/BRIEF.md
# Quasi-Resonant Gate Timer

This block sets the switching instants of a flyback converter that runs in valley-switching mode under normal load. Once the power switch turns off, the block counts falling crossings of the synchronized zero-crossing comparator. It turns the switch back on when that count reaches a requested valley number. A ringing blanking window must have expired first. The length of that window depends on the ring-level flag, sampled at the instant the switch turns off. If no valley qualifies, a maximum off time forces the next turn-on, which keeps the switching frequency from dropping into the audible range.

The on-time ends on the peak-current comparator, which is ignored during a leading-edge blanking interval. A maximum on time acts as a backstop. A separate soft-start sequencer produces a 3-bit current-limit level. After reset the level climbs one step at a fixed interval. All windows are parameters given in clock cycles.

Top module: `qr_gate_timer`

## Requirements
- R1: While `rst_n` is low, `gate_drv` is 0 and `ss_code` is 0 at every clock edge.
- R2: `ss_code` is 0 after reset and rises by one every `SS_STEP` cycles until it reaches 4, then holds. Code k stands for a current-sense limit of 0.32 V + k x 0.17 V, so 4 means 1.00 V. The code first reads k on the (k x `SS_STEP`)-th clock edge after reset release.
- R3: After a turn-off, `gate_drv` stays low for at least `RS_LONG` cycles if `ring_above` was 0 on the turn-off edge, and for at least `RS_SHORT` cycles if it was 1.
- R4: A falling edge of `zc_cmp` passes through a two-flop synchronizer and raises the crossing count one cycle later, a 3-cycle latency in total. The count saturates at 7. Once the blanking window has expired, the gate turns on at the first clock edge where the count is at least `valley_sel`.
- R5: If the gate has been low for `OFF_MAX` cycles, it turns on regardless of the crossing count or the ring-level flag.
- R6: Crossings that occur while the gate is high are not counted. The crossing count is cleared while the gate is high.
- R7: `cs_cmp` has no effect during the first `LEB` cycles of an on-time, so every on-time lasts at least `LEB` cycles.
- R8: After the blanking interval, a high `cs_cmp` turns the gate off at the next clock edge.
- R9: An on-time never exceeds `ON_MAX` cycles. Without a current trip, it lasts exactly `ON_MAX` cycles.

Top module ports:

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Synchronous active-low reset |
| zc_cmp | input | 1 | Zero-crossing comparator, high above threshold, asynchronous |
| ring_above | input | 1 | High when the zero-crossing voltage is above the ringing threshold |
| cs_cmp | input | 1 | Peak-current comparator, high when the sensed current reaches the limit |
| valley_sel | input | 3 | Number of crossings to wait for before turn-on |
| gate_drv | output | 1 | Gate command to the power switch |
| ss_code | output | 3 | Soft-start current-limit level, 0 to 4 |

## Verification
The assertions assume that `cs_cmp`, `ring_above` and `valley_sel` are synchronous to `clk`. They also assume that the window parameters keep `LEB` below `ON_MAX` and both ringing windows below `OFF_MAX`. Only `zc_cmp` is treated as asynchronous. The bench changes every input on the falling clock edge and sets the ring flag and valley number during the on-time, well before the turn-off edge. Zero-crossing pulses are placed only inside the window being measured. They stop several cycles before a phase ends, so that no edge is still inside the synchronizer when the gate changes state.

// File: rtl/qr_timing_pkg.sv
// Shared types and constants for the quasi-resonant gate timer.
package qr_timing_pkg;
    typedef enum logic {PH_OFF = 1'b0, PH_ON = 1'b1} phase_t;
    localparam int ZC_W  = 3;
    localparam int LVL_W = 3;
    localparam logic [ZC_W-1:0]  ZC_TOP = 3'd7;
    localparam logic [LVL_W-1:0] SS_TOP = 3'd4;
endpackage

// File: rtl/qr_zc_counter.sv
// Synchronizes the zero-crossing comparator and counts its falling edges
// while the gate is low. The count saturates at 7 and clears while the gate is high.
// Assumes: zc_raw is asynchronous and gate_on is a registered signal.
module qr_zc_counter
    import qr_timing_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic            zc_raw,
    input  logic            gate_on,
    output logic [ZC_W-1:0] zc_count
);
    logic [1:0] sync_q;
    logic       prev_q;
    logic       fall;

    // Two-flop synchronizer plus a delayed copy for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sync_q <= 2'b00;
            prev_q <= 1'b0;
        end else begin
            sync_q <= {sync_q[0], zc_raw};
            prev_q <= sync_q[1];
        end
    end

    assign fall = prev_q & ~sync_q[1];

    // Crossing counter: cleared during on-time, saturating increment during off-time.
    always_ff @(posedge clk) begin
        if (!rst_n || gate_on)
            zc_count <= '0;
        else if (fall && zc_count != ZC_TOP)
            zc_count <= zc_count + 3'd1;
    end

    a_r6_clear_on: assert property (@(posedge clk) disable iff (!rst_n)
        gate_on |=> zc_count == '0);
    a_r4_single_step: assert property (@(posedge clk) disable iff (!rst_n)
        !gate_on |=> (zc_count == $past(zc_count) || zc_count == $past(zc_count) + 3'd1));
endmodule

// File: rtl/qr_soft_start.sv
// Steps the soft-start current-limit level from 0 to 4 once every STEP_CYCLES cycles.
// Assumes: STEP_CYCLES >= 2.
module qr_soft_start
    import qr_timing_pkg::*;
#(
    parameter int STEP_CYCLES = 100
) (
    input  logic             clk,
    input  logic             rst_n,
    output logic [LVL_W-1:0] level
);
    localparam int CW = $clog2(STEP_CYCLES);
    localparam logic [CW-1:0] LAST = CW'(STEP_CYCLES - 1);
    localparam logic [CW-1:0] ONE  = CW'(1);

    logic [CW-1:0] tick_q;

    // Interval counter and level register; both stop once the top level is reached.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tick_q <= '0;
            level  <= '0;
        end else if (level != SS_TOP) begin
            if (tick_q == LAST) begin
                tick_q <= '0;
                level  <= level + 3'd1;
            end else begin
                tick_q <= tick_q + ONE;
            end
        end
    end

    a_r2_ceiling: assert property (@(posedge clk) disable iff (!rst_n)
        level <= SS_TOP);
    a_r2_monotonic: assert property (@(posedge clk) disable iff (!rst_n)
        ##1 (level == $past(level) || level == $past(level) + 3'd1));
endmodule

// File: rtl/qr_gate_fsm.sv
// Two-phase gate sequencer.
// Off phase: the ring flag is latched at turn-off. Turn-on happens when the blanking
// window has passed and the crossing count is at least the valley number, or when the
// maximum off time is reached.
// On phase: turn-off happens on the current comparator after leading-edge blanking,
// or at the maximum on time.
// Assumes: RS_SHORT, RS_LONG <= OFF_MAX; LEB <= ON_MAX; cs_trip and ring_high are synchronous.
module qr_gate_fsm
    import qr_timing_pkg::*;
#(
    parameter int RS_LONG  = 20,
    parameter int RS_SHORT = 8,
    parameter int OFF_MAX  = 200,
    parameter int LEB      = 6,
    parameter int ON_MAX   = 50
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            ring_high,
    input  logic            cs_trip,
    input  logic [ZC_W-1:0] zc_count,
    input  logic [ZC_W-1:0] valley,
    output logic            gate
);
    localparam int OW = $clog2(OFF_MAX);
    localparam int NW = $clog2(ON_MAX);
    localparam logic [OW-1:0] OFF_LAST = OW'(OFF_MAX - 1);
    localparam logic [OW-1:0] RSL_LAST = OW'(RS_LONG - 1);
    localparam logic [OW-1:0] RSS_LAST = OW'(RS_SHORT - 1);
    localparam logic [OW-1:0] OFF_ONE  = OW'(1);
    localparam logic [NW-1:0] ON_LAST  = NW'(ON_MAX - 1);
    localparam logic [NW-1:0] LEB_LAST = NW'(LEB - 1);
    localparam logic [NW-1:0] ON_ONE   = NW'(1);

    phase_t        phase_q;
    logic [OW-1:0] off_cnt;
    logic [NW-1:0] on_cnt;
    logic          short_q;
    logic          rs_done, go_on, go_off;

    // Turn-on and turn-off decisions from the counters and the comparator inputs.
    always_comb begin
        rs_done = short_q ? (off_cnt >= RSS_LAST) : (off_cnt >= RSL_LAST);
        go_on   = (phase_q == PH_OFF) &&
                  ((rs_done && zc_count >= valley) || off_cnt >= OFF_LAST);
        go_off  = (phase_q == PH_ON) &&
                  ((on_cnt >= LEB_LAST && cs_trip) || on_cnt >= ON_LAST);
    end

    // Phase register, per-phase cycle counters and the ring flag latched at turn-off.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase_q <= PH_OFF;
            off_cnt <= '0;
            on_cnt  <= '0;
            short_q <= 1'b0;
        end else if (go_on) begin
            phase_q <= PH_ON;
            on_cnt  <= '0;
        end else if (go_off) begin
            phase_q <= PH_OFF;
            off_cnt <= '0;
            short_q <= ring_high;
        end else if (phase_q == PH_OFF) begin
            if (off_cnt != OFF_LAST) off_cnt <= off_cnt + OFF_ONE;
        end else begin
            if (on_cnt != ON_LAST) on_cnt <= on_cnt + ON_ONE;
        end
    end

    assign gate = (phase_q == PH_ON);

    a_r3_min_window: assert property (@(posedge clk) disable iff (!rst_n)
        (!gate && off_cnt < RSS_LAST) |=> !gate);
    a_r5_forced_on: assert property (@(posedge clk) disable iff (!rst_n)
        (!gate && off_cnt == OFF_LAST) |=> gate);
    a_r7_blanking: assert property (@(posedge clk) disable iff (!rst_n)
        (gate && on_cnt < LEB_LAST) |=> gate);
    a_r9_max_on: assert property (@(posedge clk) disable iff (!rst_n)
        (gate && on_cnt == ON_LAST) |=> !gate);
endmodule

// File: rtl/qr_gate_timer.sv
// Top level of the quasi-resonant gate timer. It combines the crossing counter,
// the gate sequencer and the soft-start sequencer.
// Assumes: all inputs except zc_cmp are synchronous to clk. R1: the gate is held low in reset.
module qr_gate_timer
    import qr_timing_pkg::*;
#(
    parameter int RS_LONG  = 20,
    parameter int RS_SHORT = 8,
    parameter int OFF_MAX  = 200,
    parameter int LEB      = 6,
    parameter int ON_MAX   = 50,
    parameter int SS_STEP  = 100
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       zc_cmp,
    input  logic       ring_above,
    input  logic       cs_cmp,
    input  logic [2:0] valley_sel,
    output logic       gate_drv,
    output logic [2:0] ss_code
);
    logic [ZC_W-1:0] zc_count;

    qr_zc_counter u_zc (
        .clk      (clk),
        .rst_n    (rst_n),
        .zc_raw   (zc_cmp),
        .gate_on  (gate_drv),
        .zc_count (zc_count)
    );

    qr_gate_fsm #(
        .RS_LONG (RS_LONG), .RS_SHORT (RS_SHORT), .OFF_MAX (OFF_MAX),
        .LEB (LEB), .ON_MAX (ON_MAX)
    ) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .ring_high (ring_above),
        .cs_trip   (cs_cmp),
        .zc_count  (zc_count),
        .valley    (valley_sel),
        .gate      (gate_drv)
    );

    qr_soft_start #(.STEP_CYCLES (SS_STEP)) u_ss (
        .clk   (clk),
        .rst_n (rst_n),
        .level (ss_code)
    );

    a_r1_reset_low: assert property (@(posedge clk)
        !rst_n |=> (!gate_drv && ss_code == 3'd0));
endmodule

// File: tb/test_qr_gate_timer.sv
`timescale 1ns/1ps
module test_qr_gate_timer;
    localparam int RS_LONG = 20, RS_SHORT = 8, OFF_MAX = 200;
    localparam int LEB = 6, ON_MAX = 50, SS_STEP = 100;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic zc_cmp = 1'b1, ring_above = 1'b0, cs_cmp = 1'b1;
    logic [2:0] valley_sel = 3'd1;
    logic gate_drv;
    logic [2:0] ss_code;
    int errors = 0, checks = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    qr_gate_timer #(
        .RS_LONG (RS_LONG), .RS_SHORT (RS_SHORT), .OFF_MAX (OFF_MAX),
        .LEB (LEB), .ON_MAX (ON_MAX), .SS_STEP (SS_STEP)
    ) i_qr_gate_timer (
        .clk (clk), .rst_n (rst_n), .zc_cmp (zc_cmp), .ring_above (ring_above),
        .cs_cmp (cs_cmp), .valley_sel (valley_sel), .gate_drv (gate_drv), .ss_code (ss_code)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic wait_rise();
        logic prev = gate_drv;
        for (int t = 0; t < 3000; t++) begin
            @(negedge clk);
            if (gate_drv && !prev) return;
            prev = gate_drv;
        end
        chk("timeout waiting for gate rise", 0, 1);
    endtask

    task automatic wait_fall();
        logic prev = gate_drv;
        for (int t = 0; t < 3000; t++) begin
            @(negedge clk);
            if (!gate_drv && prev) return;
            prev = gate_drv;
        end
        chk("timeout waiting for gate fall", 0, 1);
    endtask

    // Called at the first low sample; pulses zc low at first + i*gap and returns the low width.
    task automatic run_low(input int nf, input int first, input int gap, output int width);
        width = -1;
        for (int n = 1; n < 1000; n++) begin
            for (int i = 0; i < nf; i++) begin
                if (n == first + i * gap) zc_cmp = 1'b0;
                if (n == first + i * gap + 1) zc_cmp = 1'b1;
            end
            @(negedge clk);
            if (gate_drv) begin width = n; return; end
        end
    endtask

    // Called at the first high sample; raises cs at sample cs_at (0 = already high) and returns the high width.
    task automatic run_high(input int cs_at, output int width);
        width = -1;
        for (int n = 1; n < 1000; n++) begin
            if (n == cs_at) cs_cmp = 1'b1;
            @(negedge clk);
            if (!gate_drv) begin width = n; return; end
        end
    endtask

    // R1: reset state, held for several cycles.
    task automatic t_reset_state();
        repeat (5) @(negedge clk);
        chk("R1 gate in reset", gate_drv, 0);
        chk("R1 ss_code in reset", ss_code, 0);
    endtask

    // R2: soft-start staircase counted from reset release.
    task automatic t_soft_start();
        rst_n = 1'b1;
        for (int k = 1; k <= 450; k++) begin
            @(negedge clk);
            if (k == 99 || k == 100 || k == 199 || k == 200 || k == 300 ||
                k == 399 || k == 400 || k == 450)
                chk($sformatf("R2 ss_code at edge %0d", k), ss_code,
                    (k / SS_STEP > 4) ? 4 : k / SS_STEP);
        end
    endtask

    // R3/R4/R5: set the off-phase conditions during an on-time, then measure the low width.
    task automatic t_low(input string req, input int valley, input bit ring,
                         input int nf, input int first, input int gap, input int exp);
        int w;
        wait_rise();
        valley_sel = 3'(valley); ring_above = ring; cs_cmp = 1'b1; zc_cmp = 1'b1;
        wait_fall();
        run_low(nf, first, gap, w);
        chk(req, w, exp);
    endtask

    // R7/R8/R9: measure the on width for a given current-trip time.
    task automatic t_high(input string req, input int cs_at, input int exp);
        int w;
        wait_fall();
        valley_sel = 3'd0; ring_above = 1'b1;
        cs_cmp = (cs_at == 0);
        wait_rise();
        run_high(cs_at, w);
        chk(req, w, exp);
    endtask

    // R6: crossings during the on-time must not count toward the next turn-on.
    task automatic t_ignore_on();
        int w;
        wait_fall();
        cs_cmp = 1'b0; valley_sel = 3'd1; ring_above = 1'b1; zc_cmp = 1'b1;
        wait_rise();
        w = -1;
        for (int n = 1; n < 1000; n++) begin
            if (n == 5 || n == 10 || n == 15 || n == 20) zc_cmp = 1'b0;
            if (n == 6 || n == 11 || n == 16 || n == 21) zc_cmp = 1'b1;
            @(negedge clk);
            if (!gate_drv) begin w = n; break; end
        end
        chk("R9 on width without trip", w, ON_MAX);
        cs_cmp = 1'b1;
        run_low(0, 0, 1, w);
        chk("R6 on-time crossings ignored, off width", w, OFF_MAX);
    endtask

    // R1: reset asserted during an on-time pulls the gate low at the next edge.
    task automatic t_reset_midrun();
        cs_cmp = 1'b0;
        wait_rise();
        rst_n = 1'b0;
        @(negedge clk);
        chk("R1 gate low after reset mid on-time", gate_drv, 0);
        chk("R1 ss_code cleared by reset", ss_code, 0);
    endtask

    initial begin
        t_reset_state();
        t_soft_start();
        t_low("R5 forced on with no crossings", 1, 1'b0, 0, 0, 1, OFF_MAX);
        t_low("R3 short window dominates", 2, 1'b1, 2, 2, 2, RS_SHORT);
        t_low("R3 long window dominates", 2, 1'b0, 2, 2, 2, RS_LONG);
        t_low("R4 third valley sets turn-on", 3, 1'b1, 3, 2, 4, 13);
        t_low("R4 seventh valley of nine", 7, 1'b1, 9, 2, 3, 23);
        t_low("R5 forced on when too few valleys", 5, 1'b1, 2, 2, 2, OFF_MAX);
        t_high("R7 trip held from start is blanked", 0, LEB);
        t_high("R7 trip inside blanking", 3, LEB);
        t_high("R8 trip after blanking", 12, 12);
        t_high("R9 no trip ends at max on", 999, ON_MAX);
        t_ignore_on();
        t_reset_midrun();
        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule